// File: doc/BRIEF.md
# NAND Strobe Timing Generator

This block turns byte-wide access requests from a flash controller sequencer into correctly timed NAND bus strobes. Each request asks for one read or one write byte cycle. The block pulls the matching strobe low for a programmed number of clock cycles and holds it high for a second programmed number. For a read, it captures the byte from the flash data bus. It pulses a completion flag when the cycle is over.

All timing comes from one packed timing word, counted in controller clock cycles. The word sets five things:

- the low and high phases of the read strobe;
- the low and high phases of the write strobe;
- the chip-enable setup time;
- the bus turnaround gap inserted when the transfer direction flips;
- the delay after a busy-making command before the ready/busy pin is trusted.

The sequencer raises `chip_sel` to select the device. The block drives chip enable and accepts requests only once the setup time has passed. A deselect that arrives during an access takes effect only after that access completes. A separate pulse on `busy_start` masks the device-ready indication for the programmed busy delay.

Top module: `nand_strobe_timer`

## Requirements
- R1: A write cycle drives `we_n` low for the count in timing bits [3:0], then high for the count in bits [7:4]. `done` is high in the cycle after the high phase ends. With no gap, `we_n` falls in the cycle right after the request is accepted.
- R2: A read cycle drives `re_n` low for the count in bits [11:8], then high for the count in bits [15:12]. `rd_data` takes the value `nand_din` holds in the last cycle of the low phase.
- R3: Any timing field whose value is zero behaves as a count of one cycle.
- R4: When an access has the opposite direction to the previous access under the same chip-enable period, both strobes stay high for the count in bits [18:16] before the strobe falls. There is no gap for a same-direction access, and none for the first access after chip enable is asserted.
- R5: After `chip_sel` rises, `ce_n` falls on the next clock edge. `req_ready` stays low until `ce_n` has been low for the count in bits [25:24] cycles, counting the cycle in which `req_ready` rises. A strobe is never low in the cycle where `ce_n` falls.
- R6: After a `busy_start` pulse, `dev_ready` is low for the count in bits [23:19] cycles. After that it follows `rb_n` (high means ready).
- R7: `re_n` and `we_n` are never low together, and `ce_n` is low whenever either strobe is low.
- R8: `nand_oe` is high, and `nand_dout` holds the request's write byte, through both phases of a write. `nand_oe` is low during gaps and read cycles.
- R9: A drop of `chip_sel` during an access leaves `ce_n` low until the access finishes. `ce_n` rises on the edge after the idle cycle that carries `done`.
- R10: `done` is a single-cycle pulse, one per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| timing_word | input | 32 | Packed timing fields (bits 31:26 unused) |
| chip_sel | input | 1 | Sequencer request to select the device |
| req_valid | input | 1 | Byte-cycle request present |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Request accepted on this edge if valid |
| done | output | 1 | One-cycle pulse at the end of an access |
| rd_data | output | 8 | Byte captured by the last read |
| busy_start | input | 1 | Pulse after a command that makes the device busy |
| rb_n | input | 1 | Device ready/busy pin, high = ready |
| dev_ready | output | 1 | Device ready after the busy mask expires |
| ce_n | output | 1 | Chip enable, active low |
| re_n | output | 1 | Read strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| nand_dout | output | 8 | Flash data bus output value |
| nand_oe | output | 1 | Flash data bus output enable |
| nand_din | input | 8 | Flash data bus input value |

## Verification
The in-line assertions guard, on every cycle, the relationships that hold regardless of the programmed counts:

- the two strobes are mutually exclusive;
- chip enable covers every strobe and cannot be released during an access;
- the bus is driven whenever the write strobe is low;
- the read byte is captured at the end of the low phase;
- `done` is a single-cycle pulse;
- `dev_ready` is masked right after a busy pulse.

The exact phase widths, the presence or absence of a turnaround gap across direction changes and chip-enable periods, and the zero-means-one rule depend on the timing word. Only the bench's directed scenarios show these, by counting the cycles each strobe phase lasts.

// File: rtl/nst_pkg.sv
package nst_pkg;

    localparam int CNT_W  = 5;
    localparam int WORD_W = 26;

    typedef struct packed {
        logic [1:0] ce_setup;
        logic [4:0] busy;
        logic [2:0] turn;
        logic [3:0] rd_hi;
        logic [3:0] rd_lo;
        logic [3:0] wr_hi;
        logic [3:0] wr_lo;
    } timing_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_GAP,
        PH_LOW,
        PH_HIGH
    } phase_e;

    // Number of cycles a field stands for: zero counts as one.
    function automatic logic [CNT_W-1:0] span(input logic [CNT_W-1:0] f);
        return (f == '0) ? CNT_W'(1) : f;
    endfunction

    // Value loaded into a down-counter that ends at zero.
    function automatic logic [CNT_W-1:0] load(input logic [CNT_W-1:0] f);
        return span(f) - CNT_W'(1);
    endfunction

endpackage

// File: rtl/nst_ce_gate.sv
module nst_ce_gate
    import nst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       chip_sel,
    input  logic       engine_idle,
    input  logic [1:0] setup_field,
    output logic       ce_n,
    output logic       ce_ready
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_n <= 1'b1;
            cnt  <= '0;
        end else if (ce_n) begin
            if (chip_sel) begin
                ce_n <= 1'b0;
                cnt  <= load(CNT_W'(setup_field));
            end
        end else if (!chip_sel && engine_idle) begin
            ce_n <= 1'b1;
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign ce_ready = !ce_n && (cnt == '0) && chip_sel;

    // R5: the cycle that asserts chip enable never also grants a request
    // unless the setup count is a single cycle.
    assert_setup_gate_R5: assert property (@(posedge clk) disable iff (rst)
        ($fell(ce_n) && (setup_field > 2'd1)) |-> !ce_ready);

endmodule

// File: rtl/nst_busy_wait.sv
module nst_busy_wait
    import nst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       busy_start,
    input  logic [4:0] busy_field,
    input  logic       rb_n,
    output logic       dev_ready
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (busy_start) begin
            cnt <= span(CNT_W'(busy_field));
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign dev_ready = (cnt == '0) && rb_n;

    // R6: the pin is never trusted in the cycle after a busy command
    assert_busy_mask_R6: assert property (@(posedge clk) disable iff (rst)
        busy_start |=> !dev_ready);

endmodule

// File: rtl/nst_strobe_fsm.sv
module nst_strobe_fsm
    import nst_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        wr_lo,
    input  logic [3:0]        wr_hi,
    input  logic [3:0]        rd_lo,
    input  logic [3:0]        rd_hi,
    input  logic [2:0]        turn,
    input  logic              ce_n,
    input  logic              ce_ready,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] data_in,
    output logic              req_ready,
    output logic              re_n,
    output logic              we_n,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              idle
);

    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic             is_wr;
    logic             last_wr;
    logic             dir_valid;
    logic [DATA_W-1:0] wbyte;

    logic             accept;
    logic             need_gap;
    logic [CNT_W-1:0] lo_req;
    logic [CNT_W-1:0] lo_cur;
    logic [CNT_W-1:0] hi_cur;
    logic [CNT_W-1:0] gap_ld;

    always_comb begin
        req_ready = (phase == PH_IDLE) && ce_ready;
        accept    = req_valid && req_ready;
        need_gap  = dir_valid && (last_wr != req_write);
        lo_req    = req_write ? load(CNT_W'(wr_lo)) : load(CNT_W'(rd_lo));
        lo_cur    = is_wr     ? load(CNT_W'(wr_lo)) : load(CNT_W'(rd_lo));
        hi_cur    = is_wr     ? load(CNT_W'(wr_hi)) : load(CNT_W'(rd_hi));
        gap_ld    = load(CNT_W'(turn));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            is_wr     <= 1'b0;
            last_wr   <= 1'b0;
            dir_valid <= 1'b0;
            wbyte     <= '0;
            rd_data   <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (ce_n) begin
                dir_valid <= 1'b0;
            end
            unique case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        is_wr     <= req_write;
                        last_wr   <= req_write;
                        dir_valid <= 1'b1;
                        wbyte     <= req_wdata;
                        if (need_gap) begin
                            phase <= PH_GAP;
                            cnt   <= gap_ld;
                        end else begin
                            phase <= PH_LOW;
                            cnt   <= lo_req;
                        end
                    end
                end
                PH_GAP: begin
                    if (cnt == '0) begin
                        phase <= PH_LOW;
                        cnt   <= lo_cur;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                PH_LOW: begin
                    if (cnt == '0) begin
                        phase <= PH_HIGH;
                        cnt   <= hi_cur;
                        if (!is_wr) begin
                            rd_data <= data_in;
                        end
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                PH_HIGH: begin
                    if (cnt == '0) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign re_n     = !((phase == PH_LOW) && !is_wr);
    assign we_n     = !((phase == PH_LOW) && is_wr);
    assign data_oe  = is_wr && ((phase == PH_LOW) || (phase == PH_HIGH));
    assign data_out = wbyte;
    assign idle     = (phase == PH_IDLE);

    // R7: strobes are mutually exclusive
    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(!re_n && !we_n));

    // R8: the bus is driven whenever the write strobe is low, and holds its byte
    assert_oe_covers_we_R8: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> data_oe);
    assert_wdata_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (data_oe && $past(data_oe)) |-> $stable(data_out));

    // R2: read byte taken on the edge that closes the low phase
    assert_rd_capture_R2: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_LOW) && !is_wr && (cnt == '0)) |=> (rd_data == $past(data_in)));

    // R10: completion is a single-cycle pulse
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/nand_strobe_timer.sv
module nand_strobe_timer
    import nst_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       timing_word,
    input  logic              chip_sel,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    input  logic              busy_start,
    input  logic              rb_n,
    output logic              dev_ready,
    output logic              ce_n,
    output logic              re_n,
    output logic              we_n,
    output logic [DATA_W-1:0] nand_dout,
    output logic              nand_oe,
    input  logic [DATA_W-1:0] nand_din
);

    timing_t tw;
    logic    tw_unused;
    logic    ce_ready;
    logic    eng_idle;

    assign tw        = timing_t'(timing_word[WORD_W-1:0]);
    assign tw_unused = ^timing_word[31:WORD_W];

    nst_ce_gate u_ce (
        .clk         (clk),
        .rst         (rst),
        .chip_sel    (chip_sel),
        .engine_idle (eng_idle),
        .setup_field (tw.ce_setup),
        .ce_n        (ce_n),
        .ce_ready    (ce_ready)
    );

    nst_busy_wait u_busy (
        .clk        (clk),
        .rst        (rst),
        .busy_start (busy_start),
        .busy_field (tw.busy),
        .rb_n       (rb_n),
        .dev_ready  (dev_ready)
    );

    nst_strobe_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .wr_lo     (tw.wr_lo),
        .wr_hi     (tw.wr_hi),
        .rd_lo     (tw.rd_lo),
        .rd_hi     (tw.rd_hi),
        .turn      (tw.turn),
        .ce_n      (ce_n),
        .ce_ready  (ce_ready),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .data_in   (nand_din),
        .req_ready (req_ready),
        .re_n      (re_n),
        .we_n      (we_n),
        .data_out  (nand_dout),
        .data_oe   (nand_oe),
        .rd_data   (rd_data),
        .done      (done),
        .idle      (eng_idle)
    );

    // R7: chip enable covers every strobe
    assert_ce_covers_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        (!re_n || !we_n) |-> !ce_n);

    // R5: no strobe in the cycle chip enable falls
    assert_no_strobe_at_ce_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(ce_n) |-> (re_n && we_n));

    // R9: chip enable is not released while an access is running
    assert_ce_held_R9: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !eng_idle) |=> !ce_n);

endmodule

// File: tb/nand_strobe_timer_test.sv
module nand_strobe_timer_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] timing_word;
    logic        chip_sel;
    logic        req_valid;
    logic        req_write;
    logic [7:0]  req_wdata;
    logic        req_ready;
    logic        done;
    logic [7:0]  rd_data;
    logic        busy_start;
    logic        rb_n;
    logic        dev_ready;
    logic        ce_n;
    logic        re_n;
    logic        we_n;
    logic [7:0]  nand_dout;
    logic        nand_oe;
    logic [7:0]  nand_din;

    int vectors = 0;
    int miscompares = 0;

    always #2 clk = ~clk;

    nand_strobe_timer #(.DATA_W(8)) uut (
        .clk         (clk),
        .rst         (rst),
        .timing_word (timing_word),
        .chip_sel    (chip_sel),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_wdata   (req_wdata),
        .req_ready   (req_ready),
        .done        (done),
        .rd_data     (rd_data),
        .busy_start  (busy_start),
        .rb_n        (rb_n),
        .dev_ready   (dev_ready),
        .ce_n        (ce_n),
        .re_n        (re_n),
        .we_n        (we_n),
        .nand_dout   (nand_dout),
        .nand_oe     (nand_oe),
        .nand_din    (nand_din)
    );

    function automatic logic [31:0] pack(input int c, input int b, input int t,
                                         input int rh, input int rl,
                                         input int wh, input int wl);
        return {6'd0, c[1:0], b[4:0], t[2:0], rh[3:0], rl[3:0], wh[3:0], wl[3:0]};
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; chip_sel = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_wdata = 8'h00; busy_start = 1'b0; rb_n = 1'b1; nand_din = 8'h00;
        timing_word = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R5", "reset ce_n", int'(ce_n), 1);
        check("R7", "reset strobes", int'({re_n, we_n}), 3);
        check("R10", "reset done", int'(done), 0);
        check("R8", "reset oe", int'(nand_oe), 0);
        check("R5", "reset req_ready", int'(req_ready), 0);
        check("R6", "reset dev_ready", int'(dev_ready), 1);
    endtask

    // R5: select the chip and count chip-enable cycles until a request is granted
    task automatic t_ce_setup(input int field, input int exp);
        int n = 0;
        int guard = 0;
        check("R5", "ce_n before select", int'(ce_n), 1);
        chip_sel = 1'b1;
        @(negedge clk);
        while (!req_ready && guard < 50) begin
            if (!ce_n) n++;
            check("R5", "strobe during setup", int'({re_n, we_n}), 3);
            @(negedge clk);
            guard++;
        end
        if (!ce_n) n++;
        check("R5", $sformatf("setup cycles field %0d", field), n, exp);
    endtask

    // One byte cycle, measuring gap, low and high phases (R1 R2 R4 R8 R10)
    task automatic t_access(input string req, input bit wr, input logic [7:0] wb,
                            input int exp_gap, input int exp_lo, input int exp_hi,
                            input bit drop_sel);
        int gap = 0;
        int lo = 0;
        int hi = 0;
        int bad_oe = 0;
        int bad_ce = 0;
        int bad_other = 0;
        int ph = 0;
        int guard = 0;
        logic [7:0] lowval = 8'h00;
        logic strobe;
        while (!req_ready && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        req_valid = 1'b1; req_write = wr; req_wdata = wb;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!done && guard < 200) begin
            strobe = wr ? we_n : re_n;
            if (wr ? !re_n : !we_n) bad_other++;
            if (!strobe) begin
                ph = 1;
                lo++;
                if (wr && (!nand_oe || nand_dout != wb)) bad_oe++;
                if (!wr && nand_oe) bad_oe++;
                if (drop_sel && lo == 1) chip_sel = 1'b0;
            end else if (ph == 0) begin
                gap++;
                if (nand_oe) bad_oe++;
            end else begin
                hi++;
                if (wr && (!nand_oe || nand_dout != wb)) bad_oe++;
                if (!wr && nand_oe) bad_oe++;
            end
            if (ce_n) bad_ce++;
            nand_din = nand_din + 8'h1d;
            if (!strobe) lowval = nand_din;
            @(negedge clk);
            guard++;
        end
        check(req, "gap cycles (R4)", gap, exp_gap);
        check(req, wr ? "we_n low cycles (R1)" : "re_n low cycles (R2)", lo, exp_lo);
        check(req, wr ? "we_n high cycles (R1)" : "re_n high cycles (R2)", hi, exp_hi);
        check("R8", "bus drive errors", bad_oe, 0);
        check("R7", "ce_n high during access", bad_ce, 0);
        check("R7", "other strobe low", bad_other, 0);
        if (!wr) check("R2", "captured byte", int'(rd_data), int'(lowval));
        if (drop_sel) check("R9", "ce_n held at done", int'(ce_n), 0);
        @(negedge clk);
        check("R10", "done width", int'(done), 0);
        if (drop_sel) check("R9", "ce_n released after done", int'(ce_n), 1);
    endtask

    // R6: count masked cycles after a busy command, then follow the pin
    task automatic t_busy(input int field, input int exp);
        int n = 0;
        int guard = 0;
        timing_word[23:19] = field[4:0];
        busy_start = 1'b1;
        @(negedge clk);
        busy_start = 1'b0;
        while (!dev_ready && guard < 100) begin
            n++;
            @(negedge clk);
            guard++;
        end
        check("R6", $sformatf("busy mask field %0d", field), n, exp);
        rb_n = 1'b0;
        @(negedge clk);
        check("R6", "follows rb_n low", int'(dev_ready), 0);
        rb_n = 1'b1;
        @(negedge clk);
        check("R6", "follows rb_n high", int'(dev_ready), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        t_reset();
        timing_word = pack(3, 7, 4, 2, 5, 3, 2);
        t_ce_setup(3, 3);
        t_access("R1", 1'b1, 8'hA5, 0, 2, 3, 1'b0);
        t_access("R4", 1'b1, 8'h3C, 0, 2, 3, 1'b0);
        t_access("R4", 1'b0, 8'h00, 4, 5, 2, 1'b0);
        t_access("R2", 1'b0, 8'h00, 0, 5, 2, 1'b0);
        t_access("R4", 1'b1, 8'h5A, 4, 2, 3, 1'b0);
        timing_word = '0;
        t_access("R3", 1'b1, 8'h81, 0, 1, 1, 1'b0);
        t_access("R3", 1'b0, 8'h00, 1, 1, 1, 1'b0);
        timing_word = pack(0, 0, 7, 0, 0, 15, 15);
        t_access("R1", 1'b1, 8'hF0, 7, 15, 15, 1'b0);
        t_busy(7, 7);
        t_busy(0, 1);
        t_busy(31, 31);
        t_access("R9", 1'b0, 8'h00, 7, 1, 1, 1'b1);
        t_ce_setup(0, 1);
        t_access("R4", 1'b1, 8'h66, 0, 15, 15, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule